// File: doc/BRIEF.md
# Teletext Control Register Bank with Page-Memory Preset

This block holds the control registers of a four-circuit teletext page decoder together with the page memory they address. A host reaches thirteen byte-wide register slots through a simple byte port. It opens a transfer by pulsing `host_start` with a slot number. After that, each byte it writes or reads moves the slot pointer on by one, so one transfer can stream through several registers. Slots 0 to 10 and 12 are write-only configuration. Slot 11 is the window into page memory. A view bit can turn slot 11 into a read-only status register.

When reset is released, the registers already hold their fixed defaults. A sequencer then walks the whole page memory, writing one byte per clock. It stores a space character everywhere except one location: chapter 0, row 0, column 7 receives the alpha-white control code. While the walk runs, `preset_busy` is high and host traffic through the memory window is refused.

Each chapter is a 1024-byte region, and chapter `c` starts at byte `c*1024`. Inside a chapter, the byte for row `r` and column `k` sits at offset `r*40 + k`. Rows run from 0 to 24 and columns from 0 to 39.

Top module: `ttx_ctrl_bank`

## Requirements
- R1: While reset is held and at its release, each configuration slot is 0x00, except slots 5 and 6, which are 0x03; slot 11 of `cfg_regs` is 0x00; `refresh_en` is 0 and `preset_busy` is 1.
- R2: After reset is released, `preset_busy` stays high for exactly 2^(CH_BITS+10) clock cycles and then stays low until the next reset.
- R3: Once the walk ends, every byte at rows 0..24 and columns 0..39 of every chapter reads 0x20, except chapter 0, row 0, column 7, which reads 0x07.
- R4: `host_start` loads the slot pointer from `host_addr` and makes no access. Each write or read byte without `host_start` advances the pointer by one. From slot 12, or from any value above 12, the pointer moves to 0.
- R5: A write to slot 0..10 or 12 stores `host_wdata` ANDed with that slot's mask: slot 0 0x1F, slot 1 0x7F, slot 8 0x0F, slot 9 0x1F, slot 10 0x3F, slot 12 0x38, all others 0xFF. Masked (reserved) bits read zero on `cfg_regs` (slot `i` at bits `i*8+7 : i*8`). Slot 11 of `cfg_regs` is always zero.
- R6: A read of slot 0..10, 12, 13, 14 or 15 returns 0x00.
- R7: With the view bit (slot 1, bit 2) clear, a write to slot 11 stores the byte into memory at chapter = slot 8 bits [CH_BITS-1:0], row = slot 9, column = slot 10. A read of slot 11 returns the byte at that location.
- R8: With the view bit set, a read of slot 11 returns `status_in` as sampled in the request cycle, and a write to slot 11 leaves memory unchanged.
- R9: While `preset_busy` is high, writes to slot 11 are dropped and reads of slot 11 return 0x00.
- R10: `refresh_en` follows slot 12 bit 5, and `refresh_circuit` follows slot 12 bits 4:3.
- R11: `host_rvalid` is high in exactly the cycle after each read request and at no other time. `host_rdata` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start | input | 1 | Load slot pointer from host_addr |
| host_addr | input | 4 | Slot number for host_start |
| host_wr | input | 1 | Write one byte at the pointer |
| host_rd | input | 1 | Read one byte at the pointer |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid |
| status_in | input | 8 | Decoder status shown in slot 11 view |
| cfg_regs | output | 104 | All slots, slot i at bits i*8+7:i*8 |
| preset_busy | output | 1 | Memory preset walk in progress |
| refresh_en | output | 1 | Refresh-on-display enable |
| refresh_circuit | output | 2 | Circuit used for refresh |

## Verification
Several properties are checked on every cycle: the pointer load and its advance with wrap, the one-cycle read-valid timing, the zero returned from write-only slots, reserved bits staying clear, and the busy flag never rising again once it has dropped. Other behaviours are shown only by the bench. These are the memory contents left by the walk, the exact length of the busy period, the mapping from chapter, row and column to memory, the status view, and the refusal of memory writes during the walk. The bench shows them by sweeping every row and column of every chapter and by repeating reset.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int NUM_SLOTS   = 13;
  localparam int DATA_SLOT   = 11;
  localparam int LAST_SLOT   = 12;
  localparam int VIEW_SLOT   = 1;
  localparam int VIEW_BIT    = 2;
  localparam int CHAP_SLOT   = 8;
  localparam int ROW_SLOT    = 9;
  localparam int COL_SLOT    = 10;
  localparam int REFR_SLOT   = 12;
  localparam int OFF_BITS    = 10;
  localparam int ROW_LEN     = 40;
  localparam int MARK_OFFSET = 7;
  localparam logic [7:0] SPACE_CHAR  = 8'h20;
  localparam logic [7:0] ALPHA_WHITE = 8'h07;

  function automatic logic [7:0] slot_mask(input int idx);
    case (idx)
      0:       return 8'h1F;
      1:       return 8'h7F;
      8:       return 8'h0F;
      9:       return 8'h1F;
      10:      return 8'h3F;
      11:      return 8'h00;
      12:      return 8'h38;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] slot_reset(input int idx);
    return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction
endpackage

// File: rtl/ttx_page_mem.sv
module ttx_page_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ttx_preset_seq.sv
module ttx_preset_seq
  import ttx_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [7:0]    wdata
);
  logic [AW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == {AW{1'b1}}) busy_q <= 1'b0;
    end
  end

  assign busy  = busy_q;
  assign we    = busy_q;
  assign addr  = cnt_q;
  assign wdata = (cnt_q == AW'(MARK_OFFSET)) ? ALPHA_WHITE : SPACE_CHAR;
endmodule

// File: rtl/ttx_reg_file.sv
module ttx_reg_file
  import ttx_pkg::*;
#(
  parameter int CH_BITS = 1,
  parameter int AW      = CH_BITS + OFF_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy,
  input  logic                   host_start,
  input  logic [3:0]             host_addr,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [7:0]             host_wdata,
  input  logic [7:0]             status_in,
  input  logic [7:0]             mem_q,
  output logic [NUM_SLOTS*8-1:0] cfg_flat,
  output logic [3:0]             ptr,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  output logic [7:0]             host_rdata,
  output logic                   host_rvalid
);
  logic [7:0] slots [NUM_SLOTS];
  logic [3:0] ptr_q;
  logic       rvalid_q, sel_mem_q;
  logic [7:0] word_q;

  wire do_wr   = !host_start && host_wr;
  wire do_rd   = !host_start && host_rd;
  wire at_data = (ptr_q == 4'(DATA_SLOT));
  wire view    = slots[VIEW_SLOT][VIEW_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= slot_reset(i);
    end else begin
      if (host_start)
        ptr_q <= host_addr;
      else if (host_wr || host_rd)
        ptr_q <= (ptr_q >= 4'(LAST_SLOT)) ? 4'd0 : ptr_q + 4'd1;
      for (int i = 0; i < NUM_SLOTS; i++)
        if (do_wr && ptr_q == 4'(i) && i != DATA_SLOT)
          slots[i] <= host_wdata & slot_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      sel_mem_q <= 1'b0;
      word_q    <= '0;
    end else begin
      rvalid_q  <= do_rd;
      sel_mem_q <= at_data && !view && !busy;
      word_q    <= (at_data && view) ? status_in : 8'h00;
    end
  end

  logic [OFF_BITS-1:0] offset;
  assign offset = OFF_BITS'(slots[ROW_SLOT][4:0]) * OFF_BITS'(ROW_LEN)
                + OFF_BITS'(slots[COL_SLOT][5:0]);
  assign mem_addr  = {slots[CHAP_SLOT][CH_BITS-1:0], offset};
  assign mem_we    = do_wr && at_data && !view && !busy;
  assign mem_wdata = host_wdata;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
    assign cfg_flat[g*8 +: 8] = slots[g];
  end

  assign ptr         = ptr_q;
  assign host_rvalid = rvalid_q;
  assign host_rdata  = sel_mem_q ? mem_q : word_q;
endmodule

// File: rtl/ttx_ctrl_bank.sv
module ttx_ctrl_bank
  import ttx_pkg::*;
#(
  parameter int CH_BITS = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_start,
  input  logic [3:0]             host_addr,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic                   host_rvalid,
  input  logic [7:0]             status_in,
  output logic [NUM_SLOTS*8-1:0] cfg_regs,
  output logic                   preset_busy,
  output logic                   refresh_en,
  output logic [1:0]             refresh_circuit
);
  localparam int AW = CH_BITS + OFF_BITS;

  logic          seq_we, host_we, m_we;
  logic [AW-1:0] seq_addr, host_maddr, m_waddr;
  logic [7:0]    seq_wdata, host_mwdata, m_wdata, mem_q;
  logic [3:0]    host_ptr;

  ttx_preset_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .busy(preset_busy),
    .we(seq_we), .addr(seq_addr), .wdata(seq_wdata)
  );

  ttx_reg_file #(.CH_BITS(CH_BITS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .busy(preset_busy),
    .host_start(host_start), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .status_in(status_in), .mem_q(mem_q), .cfg_flat(cfg_regs),
    .ptr(host_ptr), .mem_we(host_we), .mem_addr(host_maddr),
    .mem_wdata(host_mwdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid)
  );

  assign m_we    = preset_busy ? seq_we    : host_we;
  assign m_waddr = preset_busy ? seq_addr  : host_maddr;
  assign m_wdata = preset_busy ? seq_wdata : host_mwdata;

  ttx_page_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr(host_maddr), .rdata(mem_q)
  );

  assign refresh_en      = cfg_regs[REFR_SLOT*8 + 5];
  assign refresh_circuit = cfg_regs[REFR_SLOT*8 + 3 +: 2];
endmodule

// File: rtl/ttx_ctrl_bank_chk.sv
module ttx_ctrl_bank_chk (
  input logic         clk,
  input logic         rst,
  input logic         host_start,
  input logic [3:0]   host_addr,
  input logic         host_wr,
  input logic         host_rd,
  input logic [7:0]   host_rdata,
  input logic         host_rvalid,
  input logic [103:0] cfg_regs,
  input logic         preset_busy,
  input logic [3:0]   host_ptr
);
  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    host_start |=> host_ptr == $past(host_addr));

  // R4
  ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_start && (host_wr || host_rd)) |=>
      host_ptr == (($past(host_ptr) >= 4'd12) ? 4'd0 : $past(host_ptr) + 4'd1));

  // R11
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_start) |=> host_rvalid);

  // R11
  rvalid_only_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_rd && !host_start));

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_start && host_ptr != 4'd11) |=> host_rdata == 8'h00);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_regs[7:5] == 3'b0 && cfg_regs[103:102] == 2'b0 &&
    cfg_regs[98:96] == 3'b0 && cfg_regs[95:88] == 8'h00);

  // R2
  busy_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    !preset_busy |=> !preset_busy);
endmodule

bind ttx_ctrl_bank ttx_ctrl_bank_chk u_chk (
  .clk(clk), .rst(rst), .host_start(host_start), .host_addr(host_addr),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .host_rvalid(host_rvalid), .cfg_regs(cfg_regs),
  .preset_busy(preset_busy), .host_ptr(host_ptr)
);

// File: tb/ttx_ctrl_bank_test.sv
module ttx_ctrl_bank_test;
  localparam int CHB   = 1;
  localparam int DEPTH = 1 << (CHB + 10);

  logic         clk = 0, rst = 1;
  logic         host_start = 0, host_wr = 0, host_rd = 0;
  logic [3:0]   host_addr = 0;
  logic [7:0]   host_wdata = 0, status_in = 0;
  logic [7:0]   host_rdata;
  logic         host_rvalid, preset_busy, refresh_en;
  logic [1:0]   refresh_circuit;
  logic [103:0] cfg_regs;
  int checks = 0, failures = 0;
  bit done = 0;

  ttx_ctrl_bank #(.CH_BITS(CHB)) uut (
    .clk(clk), .rst(rst), .host_start(host_start), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .status_in(status_in),
    .cfg_regs(cfg_regs), .preset_busy(preset_busy), .refresh_en(refresh_en),
    .refresh_circuit(refresh_circuit)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_mask(input int i);
    if (i == 0 || i == 9) return 8'h1F;
    if (i == 1) return 8'h7F;
    if (i == 8) return 8'h0F;
    if (i == 10) return 8'h3F;
    if (i == 11) return 8'h00;
    if (i == 12) return 8'h38;
    return 8'hFF;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [3:0] a, input logic w,
                      input logic r, input logic [7:0] d);
    host_start = s; host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
    @(negedge clk);
    host_start = 0; host_wr = 0; host_rd = 0;
  endtask

  task automatic wreg(input int a, input int d);
    step(1, 4'(a), 0, 0, 0);
    step(0, 0, 1, 0, 8'(d));
  endtask

  task automatic rd_byte(output logic [7:0] v, output logic vld);
    step(0, 0, 0, 1, 0);
    v = host_rdata; vld = host_rvalid;
  endtask

  task automatic setpos(input int ch, input int row, input int col);
    step(1, 4'd8, 0, 0, 0);
    step(0, 0, 1, 0, 8'(ch));
    step(0, 0, 1, 0, 8'(row));
    step(0, 0, 1, 0, 8'(col));
  endtask

  task automatic do_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic check_defaults;
    for (int i = 0; i < 13; i++)
      check(cfg_regs[i*8 +: 8] == ((i == 5 || i == 6) ? 8'h03 : 8'h00),
            "R1 slot default", cfg_regs[i*8 +: 8], (i == 5 || i == 6) ? 3 : 0);
    check(refresh_en == 0, "R1 refresh off", refresh_en, 0);
    check(preset_busy == 1, "R1 busy at release", preset_busy, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic vld;
    int n;
    @(negedge clk);
    do_reset();
    check_defaults();
    // R2: busy length
    n = 0;
    while (preset_busy) begin n++; @(negedge clk); end
    check(n == DEPTH, "R2 busy cycles", n, DEPTH);
    repeat (5) @(negedge clk);
    check(preset_busy == 0, "R2 busy stays low", preset_busy, 0);

    // R3 / R7: sweep every location
    for (int ch = 0; ch < (1 << CHB); ch++)
      for (int row = 0; row < 25; row++)
        for (int col = 0; col < 40; col++) begin
          setpos(ch, row, col);
          rd_byte(v, vld);
          check(vld && v == ((ch == 0 && row == 0 && col == 7) ? 8'h07 : 8'h20),
                "R3 preset content", v, (ch == 0 && row == 0 && col == 7) ? 7 : 32);
        end

    // R5: masks
    for (int i = 0; i < 13; i++) begin
      if (i == 11) continue;
      wreg(i, 8'hFF);
      check(cfg_regs[i*8 +: 8] == exp_mask(i), "R5 slot mask", cfg_regs[i*8 +: 8], exp_mask(i));
    end
    check(cfg_regs[88 +: 8] == 0, "R5 slot 11 zero", cfg_regs[88 +: 8], 0);
    // R10
    check(refresh_en == 1 && refresh_circuit == 3, "R10 refresh full", {refresh_en, refresh_circuit}, 7);
    wreg(12, 8'h10);
    check(refresh_en == 0 && refresh_circuit == 2, "R10 refresh circ", {refresh_en, refresh_circuit}, 2);

    // R6 / R11: write-only reads
    for (int a = 0; a < 16; a++) begin
      if (a == 11) continue;
      step(1, 4'(a), 0, 0, 0);
      check(host_rvalid == 0, "R11 no rvalid idle", host_rvalid, 0);
      rd_byte(v, vld);
      check(vld == 1, "R11 rvalid after read", vld, 1);
      check(v == 0, "R6 write-only reads zero", v, 0);
    end

    // R4: wrap and out-of-range pointer
    step(1, 4'd12, 0, 0, 0);
    step(0, 0, 1, 0, 8'h08);
    step(0, 0, 1, 0, 8'hAA);
    check(cfg_regs[96 +: 8] == 8'h08, "R4 stream slot 12", cfg_regs[96 +: 8], 8);
    check(cfg_regs[0 +: 8] == 8'h0A, "R4 wrap to slot 0", cfg_regs[0 +: 8], 10);
    step(1, 4'd13, 0, 0, 0);
    step(0, 0, 1, 0, 8'h55);
    check(cfg_regs[0 +: 8] == 8'h0A, "R4 slot 13 ignored", cfg_regs[0 +: 8], 10);
    step(0, 0, 1, 0, 8'h03);
    check(cfg_regs[0 +: 8] == 8'h03, "R4 13 wraps to 0", cfg_regs[0 +: 8], 3);

    // R8: status view (slot 1 = 0x7F has bit 2 set)
    status_in = 8'h5A;
    step(1, 4'd11, 0, 0, 0);
    rd_byte(v, vld);
    check(v == 8'h5A, "R8 status read", v, 8'h5A);
    setpos(1, 3, 5);
    step(0, 0, 1, 0, 8'h99);
    wreg(1, 8'h00);
    setpos(1, 3, 5);
    rd_byte(v, vld);
    check(v == 8'h20, "R8 status write ignored", v, 8'h20);

    // R7: memory write then read
    setpos(1, 3, 5);
    step(0, 0, 1, 0, 8'h41);
    setpos(1, 3, 5);
    rd_byte(v, vld);
    check(v == 8'h41, "R7 write readback", v, 8'h41);
    setpos(0, 24, 39);
    step(0, 0, 1, 0, 8'hC3);
    setpos(0, 24, 39);
    rd_byte(v, vld);
    check(v == 8'hC3, "R7 last cell", v, 8'hC3);
    setpos(0, 24, 38);
    rd_byte(v, vld);
    check(v == 8'h20, "R7 neighbour untouched", v, 8'h20);

    // R9: memory window refused during walk
    do_reset();
    check_defaults();
    setpos(0, 0, 0);
    step(0, 0, 1, 0, 8'h77);
    step(1, 4'd11, 0, 0, 0);
    rd_byte(v, vld);
    check(preset_busy == 1, "R9 still busy", preset_busy, 1);
    check(v == 8'h00, "R9 read during busy", v, 0);
    while (preset_busy) @(negedge clk);
    setpos(0, 0, 0);
    rd_byte(v, vld);
    check(v == 8'h20, "R9 write during busy dropped", v, 8'h20);
    setpos(1, 3, 5);
    rd_byte(v, vld);
    check(v == 8'h20, "R3 preset restored", v, 8'h20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule